// File: doc/BRIEF.md
# Geometry Command Queue with Staging Pipe

This block buffers work for a 3D geometry engine. A host writes pairs of an 8-bit command code and a 32-bit parameter into a main queue of 256 entries. The engine does not read the main queue directly. It reads from a staging pipe of up to four entries, which the block tops up from the main queue one entry per cycle, so the next command is always waiting at the consumer's port.

A packed 32-bit status word shows the main-queue occupancy, an empty flag, a below-half flag and a busy flag. The busy flag also covers work still held in the pipe and a command the engine is still executing. A control write with bit 29 set flushes the main queue and the pipe in one step. A writer that meets a full main queue is held off through a ready signal, so no entry is lost.

Top module: `gcmd_queue`

## Requirements
- R1: Each accepted write stores an 8-bit command and a 32-bit parameter as one entry. Entries reach `outCmd`/`outParam` unchanged and in the order they were written.
- R2: The main queue holds at most 256 entries. While it holds 256, `wrReady` is low and a presented write is not taken. The write is taken once space frees up.
- R3: Status bits 24:16 give the main-queue occupancy (0 to 256). Entries already moved into the staging pipe are not counted.
- R4: Status bit 26 is set exactly when the main queue is empty. Bit 25 is set exactly when the occupancy is below 128. Bits 15:0 and 31:28 read zero.
- R5: Status bit 27 (busy) is set while the main queue or the pipe holds an entry, or while `consumerBusy` is high.
- R6: A cycle with `ctlWrite` high and `ctlData[29]` high empties both the main queue and the pipe by the next cycle. After it, the status reads occupancy 0 with bits 25 and 26 set, `outValid` is low, and `wrReady` is low during that cycle. A control write with bit 29 low has no effect.
- R7: The pipe holds at most 4 entries. When it holds fewer than 2, it starts moving one entry per cycle from the main queue. It keeps doing so until it holds 4 or the main queue is empty.
- R8: `outValid` is high while the pipe holds an entry. An entry leaves on a cycle with `outValid` and `outReady` both high. While it is not taken, `outCmd`/`outParam` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Host presents a command/parameter pair |
| wrCmd | input | 8 | Command code to enqueue |
| wrParam | input | 32 | Parameter to enqueue |
| wrReady | output | 1 | Main queue can take the pair this cycle |
| ctlWrite | input | 1 | Control word write strobe |
| ctlData | input | 32 | Control word; bit 29 flushes both queues |
| status | output | 32 | Packed occupancy and flag word |
| outValid | output | 1 | Pipe head entry is available |
| outCmd | output | 8 | Command at the pipe head |
| outParam | output | 32 | Parameter at the pipe head |
| outReady | input | 1 | Consumer takes the head entry |
| consumerBusy | input | 1 | Consumer is still executing a command |

## Verification
The bench fills the main queue to exactly 256 behind a stalled consumer. A design with an off-by-one full test would either drop the 257th entry or report an occupancy of 255 or 257. It issues a flush while entries sit in both the pipe and the main queue. A design that cleared only one of them would keep `outValid` high or leave a nonzero count. It also checks that the pipe fills to four after starting below two: a design without the fill-until-full behaviour would stall at two, and the main-queue count would come out two higher. Long random runs mix pops, stalls, rare flushes and the consumer-busy input, and catch busy or below-half flags that follow the wrong occupancy.

// File: rtl/gcq_pkg.sv
package gcq_pkg;
  typedef struct packed {
    logic push;
    logic refill;
    logic pop;
    logic clear;
  } gcq_strobe_t;

  localparam int STAT_CNT_LSB = 16;
  localparam int STAT_CNT_W   = 9;
  localparam int STAT_LOWHALF = 25;
  localparam int STAT_EMPTY   = 26;
  localparam int STAT_BUSY    = 27;
  localparam int CTL_CLEAR    = 29;
endpackage

// File: rtl/gcq_ctrl.sv
module gcq_ctrl
  import gcq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 256,
  parameter int PIPE_DEPTH   = 4,
  parameter int REFILL_LEVEL = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        ctlWrite,
  input  logic        ctlClearBit,
  input  logic        outReady,
  input  logic        consumerBusy,
  output gcq_strobe_t strb,
  output logic        wrReady,
  output logic        outValid,
  output logic [31:0] status
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int PCNT_W = $clog2(PIPE_DEPTH + 1);

  logic [CNT_W-1:0]  fifoCount, fifoNext;
  logic [PCNT_W-1:0] pipeCount, pipeNext;
  logic              refillOn, refillNext;
  logic              clearReq;

  always_comb begin
    clearReq    = ctlWrite && ctlClearBit;
    wrReady     = !clearReq && (fifoCount != CNT_W'(FIFO_DEPTH));
    outValid    = (pipeCount != '0);
    strb.clear  = clearReq;
    strb.push   = wrValid && wrReady;
    strb.pop    = outValid && outReady && !clearReq;
    strb.refill = !clearReq && (fifoCount != '0)
                  && (pipeCount < PCNT_W'(PIPE_DEPTH))
                  && ((pipeCount < PCNT_W'(REFILL_LEVEL)) || refillOn);
  end

  always_comb begin
    fifoNext = fifoCount + CNT_W'(strb.push) - CNT_W'(strb.refill);
    pipeNext = pipeCount + PCNT_W'(strb.refill) - PCNT_W'(strb.pop);
    if (pipeNext < PCNT_W'(REFILL_LEVEL))    refillNext = 1'b1;
    else if (pipeNext == PCNT_W'(PIPE_DEPTH)) refillNext = 1'b0;
    else                                      refillNext = refillOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearReq) begin
      fifoCount <= '0;
      pipeCount <= '0;
      refillOn  <= 1'b0;
    end else begin
      fifoCount <= fifoNext;
      pipeCount <= pipeNext;
      refillOn  <= refillNext;
    end
  end

  always_comb begin
    status = '0;
    status[STAT_CNT_LSB +: STAT_CNT_W] = STAT_CNT_W'(fifoCount);
    status[STAT_LOWHALF] = (fifoCount < CNT_W'(FIFO_DEPTH / 2));
    status[STAT_EMPTY]   = (fifoCount == '0);
    status[STAT_BUSY]    = (fifoCount != '0) || (pipeCount != '0) || consumerBusy;
  end
endmodule

// File: rtl/gcq_data.sv
module gcq_data
  import gcq_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int PARAM_W    = 32,
  parameter int FIFO_DEPTH = 256,
  parameter int PIPE_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  gcq_strobe_t        strb,
  input  logic [CMD_W-1:0]   wrCmd,
  input  logic [PARAM_W-1:0] wrParam,
  output logic [CMD_W-1:0]   outCmd,
  output logic [PARAM_W-1:0] outParam
);
  localparam int ENT_W = CMD_W + PARAM_W;
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int PAW   = $clog2(PIPE_DEPTH);

  logic [ENT_W-1:0] mem     [FIFO_DEPTH];
  logic [ENT_W-1:0] pipeMem [PIPE_DEPTH];
  logic [AW-1:0]    head, tail;
  logic [PAW-1:0]   pRd, pWr;
  logic [ENT_W-1:0] headEntry;

  function automatic logic [AW-1:0] fifoInc(input logic [AW-1:0] p);
    return (p == AW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PAW-1:0] pipeInc(input logic [PAW-1:0] p);
    return (p == PAW'(PIPE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headEntry = mem[head];

  always_ff @(posedge clk) begin
    if (strb.push) mem[tail] <= {wrCmd, wrParam};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      head <= '0;
      tail <= '0;
      pRd  <= '0;
      pWr  <= '0;
    end else begin
      if (strb.push)   tail <= fifoInc(tail);
      if (strb.refill) head <= fifoInc(head);
      if (strb.refill) pWr  <= pipeInc(pWr);
      if (strb.pop)    pRd  <= pipeInc(pRd);
    end
  end

  generate
    for (genvar i = 0; i < PIPE_DEPTH; i++) begin : g_pipe
      always_ff @(posedge clk) begin
        if (!rstN) pipeMem[i] <= '0;
        else if (strb.refill && (pWr == PAW'(i))) pipeMem[i] <= headEntry;
      end
    end
  endgenerate

  assign {outCmd, outParam} = pipeMem[pRd];
endmodule

// File: rtl/gcmd_queue.sv
module gcmd_queue
  import gcq_pkg::*;
#(
  parameter int CMD_W        = 8,
  parameter int PARAM_W      = 32,
  parameter int FIFO_DEPTH   = 256,
  parameter int PIPE_DEPTH   = 4,
  parameter int REFILL_LEVEL = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [CMD_W-1:0]   wrCmd,
  input  logic [PARAM_W-1:0] wrParam,
  output logic               wrReady,
  input  logic               ctlWrite,
  input  logic [31:0]        ctlData,
  output logic [31:0]        status,
  output logic               outValid,
  output logic [CMD_W-1:0]   outCmd,
  output logic [PARAM_W-1:0] outParam,
  input  logic               outReady,
  input  logic               consumerBusy
);
  gcq_strobe_t strb;
  logic        unusedCtlBits;

  assign unusedCtlBits = ^{ctlData[31:CTL_CLEAR+1], ctlData[CTL_CLEAR-1:0]};

  gcq_ctrl #(
    .FIFO_DEPTH(FIFO_DEPTH), .PIPE_DEPTH(PIPE_DEPTH), .REFILL_LEVEL(REFILL_LEVEL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .ctlWrite(ctlWrite),
    .ctlClearBit(ctlData[CTL_CLEAR]), .outReady(outReady),
    .consumerBusy(consumerBusy), .strb(strb), .wrReady(wrReady),
    .outValid(outValid), .status(status)
  );

  gcq_data #(
    .CMD_W(CMD_W), .PARAM_W(PARAM_W), .FIFO_DEPTH(FIFO_DEPTH), .PIPE_DEPTH(PIPE_DEPTH)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrCmd(wrCmd), .wrParam(wrParam),
    .outCmd(outCmd), .outParam(outParam)
  );
endmodule

// File: rtl/gcq_checker.sv
module gcq_checker
  import gcq_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int PARAM_W    = 32,
  parameter int FIFO_DEPTH = 256
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrReady,
  input logic               ctlWrite,
  input logic [31:0]        ctlData,
  input logic [31:0]        status,
  input logic               outValid,
  input logic               outReady,
  input logic [CMD_W-1:0]   outCmd,
  input logic [PARAM_W-1:0] outParam,
  input gcq_strobe_t        strb
);
  logic [8:0] occ;
  assign occ = status[24:16];

  AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    occ <= 9'(FIFO_DEPTH)); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    occ == 9'(FIFO_DEPTH) |-> !wrReady); // R2
  AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    strb.push && !strb.refill |=> occ == $past(occ) + 9'd1); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrite && ctlData[29] |=> !outValid && occ == 9'd0 && status[26] && status[25]); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !(ctlWrite && ctlData[29])
    |=> outValid && $stable(outCmd) && $stable(outParam)); // R8
  AST_BUSY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> status[27]); // R5
  AST_REFILL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.refill |-> !status[26]); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    status[15:0] == 16'd0 && status[31:28] == 4'd0); // R4
endmodule

bind gcmd_queue gcq_checker #(
  .CMD_W(CMD_W), .PARAM_W(PARAM_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (.*);

// File: tb/gcmd_queue_test.sv
module gcmd_queue_test;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [7:0]  wrCmd = '0;
  logic [31:0] wrParam = '0;
  logic        wrReady;
  logic        ctlWrite = 1'b0;
  logic [31:0] ctlData = '0;
  logic [31:0] status;
  logic        outValid;
  logic [7:0]  outCmd;
  logic [31:0] outParam;
  logic        outReady = 1'b0;
  logic        consumerBusy = 1'b0;

  int total = 0;
  int bad = 0;

  logic [39:0] fq[$];
  logic [39:0] pq[$];
  bit          mRefillOn = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  gcmd_queue uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus(input bit cb);
    logic [31:0] s = '0;
    s[24:16] = 9'(fq.size());
    s[25] = fq.size() < 128;
    s[26] = fq.size() == 0;
    s[27] = (fq.size() != 0) || (pq.size() != 0) || cb;
    return s;
  endfunction

  function automatic bit expReady(input bit cw, input logic [31:0] cd);
    return !(cw && cd[29]) && (fq.size() != 256);
  endfunction

  task automatic step(input bit wv, input logic [7:0] c, input logic [31:0] p,
                      input bit cw, input logic [31:0] cd, input bit ordy, input bit cb);
    bit clr, push, pop, refill;
    logic [31:0] es;
    logic [39:0] tmp;
    @(negedge clk);
    wrValid = wv; wrCmd = c; wrParam = p; ctlWrite = cw; ctlData = cd;
    outReady = ordy; consumerBusy = cb;
    #1;
    es = expStatus(cb);
    check(wrReady == expReady(cw, cd), "R2 wrReady", 64'(wrReady), 64'(expReady(cw, cd)));
    check(status[24:16] == es[24:16], "R3 occupancy", 64'(status[24:16]), 64'(es[24:16]));
    check({status[31:28], status[26:25], status[15:0]} == {es[31:28], es[26:25], es[15:0]},
          "R4 flags", 64'(status), 64'(es));
    check(status[27] == es[27], "R5 busy", 64'(status[27]), 64'(es[27]));
    check(outValid == (pq.size() != 0), "R8 outValid", 64'(outValid), 64'(pq.size() != 0));
    if (pq.size() != 0)
      check({outCmd, outParam} == pq[0], "R1 entry order", 64'({outCmd, outParam}), 64'(pq[0]));
    clr = cw && cd[29];
    push = wv && expReady(cw, cd);
    pop = (pq.size() != 0) && ordy && !clr;
    refill = !clr && (fq.size() != 0) && (pq.size() < 4) && ((pq.size() < 2) || mRefillOn);
    if (clr) begin
      fq.delete(); pq.delete(); mRefillOn = 1'b0;
    end else begin
      if (refill) tmp = fq.pop_front();
      if (pop) void'(pq.pop_front());
      if (refill) pq.push_back(tmp);
      if (push) fq.push_back({c, p});
      if (pq.size() < 2) mRefillOn = 1'b1;
      else if (pq.size() == 4) mRefillOn = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // Reset state: empty, below half, not busy, no output
    check(status == 32'h0600_0000, "R4 reset status", 64'(status), 64'h0600_0000);
    check(!outValid && wrReady, "R8 reset handshake", 64'({outValid, wrReady}), 64'b01);

    // Fill behind a stalled consumer: 256 in queue plus 4 in pipe
    for (int i = 0; i < 265; i++)
      step(1'b1, 8'(i), 32'hA000_0000 + 32'(i), 1'b0, '0, 1'b0, 1'b0);
    #1;
    check(status[24:16] == 9'd256, "R2 full at 256", 64'(status[24:16]), 64'd256);
    check(!wrReady, "R2 stall when full", 64'(wrReady), 64'd0);
    check(pq.size() == 4, "R7 pipe filled to four", 64'(pq.size()), 64'd4);

    // Control write without bit 29 changes nothing
    step(1'b0, '0, '0, 1'b1, 32'hDFFF_FFFF, 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    check(status[24:16] == 9'd256 && outValid, "R6 no-op control",
          64'(status[24:16]), 64'd256);

    // Flush with entries in both queues, write offered in same cycle
    step(1'b1, 8'h55, 32'h1234_5678, 1'b1, 32'h2000_0000, 1'b1, 1'b0);
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    check(!outValid && status == 32'h0600_0000, "R6 flush empties",
          64'(status), 64'h0600_0000);

    // Ten writes, no pops: pipe ends at four, queue at six
    for (int i = 0; i < 10; i++)
      step(1'b1, 8'(8'hC0 + i), 32'(i * 7), 1'b0, '0, 1'b0, 1'b0);
    repeat (6) step(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    #1;
    check(status[24:16] == 9'd6, "R7 pipe takes four", 64'(status[24:16]), 64'd6);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      bit cw = ($urandom % 300) == 0;
      step(($urandom % 10) < 6, 8'($urandom), $urandom, cw,
           cw ? $urandom : 32'd0, ($urandom % 2) == 0, ($urandom % 5) == 0);
    end

    // Drain
    for (int i = 0; i < 400; i++)
      step(1'b0, '0, '0, 1'b0, '0, 1'b1, 1'b0);
    #1;
    check(status == 32'h0600_0000 && !outValid, "R5 idle after drain",
          64'(status), 64'h0600_0000);
    finishRun();
  end
endmodule